// File: doc/BRIEF.md
# Phase-Accumulating Sine Synthesizer Core

This core makes a digital sine wave at a frequency set by software. It holds a tuning word in a frequency register, which is loaded from a parallel port. On every clock, a wide phase accumulator adds that word to itself. The upper bits of the accumulator then select an amplitude. The amplitude does not come from a stored table. A small arithmetic shaper computes it from a parabola that follows a sine over each half period.

The 12-bit amplitude can be delivered in one of three number formats: two's complement, offset binary, or sign-magnitude. A bypass input skips the shaper and sends the raw upper phase bits to the output, so an external memory can produce an arbitrary waveform. A power-down input freezes every register. When it is released, the output waveform resumes from the exact phase where it stopped.

The frequency port can be built in two ways, chosen by a parameter:
- **Synchronous:** the word is captured on the clock where the strobe is high.
- **Asynchronous:** the strobe is synchronised first, and its rising edge triggers the capture.

Top module: `dds_core`

## Requirements
- R1: The tuning word is 31 bits wide and enters the 32-bit accumulator with a zero in bit 31. Even the word 0x7FFFFFFF advances the accumulator by exactly that amount on each clock.
- R2: While power-down is low, the accumulator grows by the held tuning word on every rising edge, modulo 2^32. The phase used by the output stage is accumulator bits [31:18].
- R3: In table mode, with phase p and x = p[12:0], the magnitude is m = min(floor(x*(8192-x)/8192), 2047). The sign is p[13].
- R4: With synchronous loading, a word is captured on the edge where the load strobe is high. Loads may arrive on back-to-back clocks. With asynchronous loading, if the strobe rises before edge E0, the word is captured at edge E2. Holding the strobe high causes no further loads.
- R5: The format select chooses the encoding. 00 and 11 give two's complement of ±m. 01 gives the same value with bit 11 inverted (offset binary). 10 gives {p[13], m} (sign-magnitude). The 12-bit result sits in sample[11:0], and sample[13:12] both copy bit 11.
- R6: When bypass is high, the sample is accumulator bits [31:18] taken before the edge, and the shaper's input is held at zero.
- R7: While power-down is high, the accumulator, the tuning register and the sample all hold their values, and the load port is ignored. After release, the output continues as if the power-down cycles had never happened.
- R8: Reset clears the accumulator, the tuning register and the sample to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 31 | Tuning word to load |
| load | input | 1 | Load strobe for the tuning word |
| fmt | input | 2 | Output encoding select |
| bypass | input | 1 | Send raw phase bits instead of the shaped amplitude |
| pwr_down | input | 1 | Freeze all state |
| sample | output | 14 | Registered output word |

## Verification
A wrong tuning register or accumulator shows up at the output within two edges of a load:
- In bypass, the step between successive samples differs from the loaded word.
- In table mode, the samples drift off the exhaustive parabola sweep.

A bad format mux or bad sign extension corrupts a sample on the very next edge after the select changes. A power-down that lets any register slip leaves a permanent phase offset. That offset is still visible in every sample after release.

// File: rtl/dds_pkg.sv
package dds_pkg;
   // Output number formats (2-bit select; 2'b11 is an alias of two's complement)
   typedef enum logic [1:0] {
      FMT_TWOS     = 2'b00,
      FMT_OFFSET   = 2'b01,
      FMT_SIGNMAG  = 2'b10,
      FMT_TWOS_ALT = 2'b11
   } fmt_e;
endpackage

// File: rtl/dds_tune_reg.sv
module dds_tune_reg #(
   parameter int FREQ_W     = 31,
   parameter bit ASYNC_LOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pwr_down,
   input  logic              load,
   input  logic [FREQ_W-1:0] word_in,
   output logic [FREQ_W-1:0] word_q
);
   if (FREQ_W < 2) begin : g_chk_w
      $error("dds_tune_reg: FREQ_W must be at least 2");
   end

   if (ASYNC_LOAD == 1'b0) begin : g_sync
      always_ff @(posedge clk) begin
         if (rst)                      word_q <= '0;
         else if (load && !pwr_down)   word_q <= word_in;
      end

      // R4: a strobed word appears in the register on that edge
      assert_sync_load_R4: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(load) && !$past(pwr_down)) |-> (word_q == $past(word_in)));
   end else begin : g_async
      logic [2:0] strb_q;
      logic       strb_rise;

      always_ff @(posedge clk) begin
         if (rst) strb_q <= '0;
         else     strb_q <= {strb_q[1:0], load};
      end

      assign strb_rise = strb_q[1] & ~strb_q[2];

      always_ff @(posedge clk) begin
         if (rst)                          word_q <= '0;
         else if (strb_rise && !pwr_down)  word_q <= word_in;
      end

      // R4: the register never changes without a detected strobe edge
      assert_async_edge_R4: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(strb_rise)) |-> $stable(word_q));
   end

   // R7: load port ignored while powered down
   assert_pd_noload_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pwr_down)) |-> $stable(word_q));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int FREQ_W = 31,
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pwr_down,
   input  logic [FREQ_W-1:0] word,
   output logic [ADDR_W-1:0] phase
);
   localparam int PAD_W = ACC_W - FREQ_W;

   if (FREQ_W >= ACC_W) begin : g_chk_freq
      $error("dds_phase_acc: tuning word must be narrower than the accumulator");
   end
   if (ADDR_W > ACC_W) begin : g_chk_addr
      $error("dds_phase_acc: ADDR_W exceeds ACC_W");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] inc;

   // Upper bits forced to zero: the step is always below half a cycle
   assign inc = {{PAD_W{1'b0}}, word};

   always_ff @(posedge clk) begin
      if (rst)            acc_q <= '0;
      else if (!pwr_down) acc_q <= acc_q + inc;
   end

   assign phase = acc_q[ACC_W-1 -: ADDR_W];

   // R2: accumulator advances by the held word every running cycle
   assert_step_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(pwr_down)) |-> (acc_q == $past(acc_q) + {{PAD_W{1'b0}}, $past(word)}));

   // R7: frozen while powered down
   assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pwr_down)) |-> $stable(acc_q));
endmodule

// File: rtl/dds_parabola_rom.sv
module dds_parabola_rom #(
   parameter int ADDR_W = 14,
   parameter int AMP_W  = 12
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic              sign,
   output logic [AMP_W-2:0]  mag
);
   localparam int X_W    = ADDR_W - 1;
   localparam int PROD_W = X_W + ADDR_W;
   localparam int SHIFT  = 2*ADDR_W - 3 - AMP_W;
   localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << X_W;
   localparam logic [PROD_W-1:0] MAXM = PROD_W'((1 << (AMP_W-1)) - 1);

   if (SHIFT < 0) begin : g_chk_shift
      $error("dds_parabola_rom: AMP_W too wide for ADDR_W");
   end
   if (AMP_W < 3) begin : g_chk_amp
      $error("dds_parabola_rom: AMP_W must be at least 3");
   end

   logic [ADDR_W-1:0] addr_g;
   logic [X_W-1:0]    x;
   logic [ADDR_W-1:0] comp;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] scaled;

   // Operand isolation: disabled shaper sees a constant zero address
   assign addr_g = en ? addr : '0;
   assign x      = addr_g[X_W-1:0];
   assign comp   = HALF - {1'b0, x};
   assign prod   = PROD_W'(x) * PROD_W'(comp);
   assign scaled = prod >> SHIFT;
   assign sign   = addr_g[ADDR_W-1];
   assign mag    = (scaled > MAXM) ? MAXM[AMP_W-2:0] : scaled[AMP_W-2:0];
endmodule

// File: rtl/dds_out_fmt.sv
module dds_out_fmt
   import dds_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int AMP_W  = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pwr_down,
   input  logic              bypass,
   input  logic [1:0]        fmt,
   input  logic [ADDR_W-1:0] phase,
   input  logic              sign,
   input  logic [AMP_W-2:0]  mag,
   output logic [ADDR_W-1:0] sample_q
);
   localparam int EXT_W = ADDR_W - AMP_W;

   if (ADDR_W < AMP_W) begin : g_chk_out
      $error("dds_out_fmt: output narrower than amplitude");
   end

   logic [AMP_W-1:0]  mag_ext;
   logic [AMP_W-1:0]  twos;
   logic [AMP_W-1:0]  code;
   logic [ADDR_W-1:0] wide;
   logic [ADDR_W-1:0] nxt;

   assign mag_ext = {1'b0, mag};
   assign twos    = sign ? (AMP_W'(0) - mag_ext) : mag_ext;

   always_comb begin
      case (fmt_e'(fmt))
         FMT_OFFSET:  code = twos ^ {1'b1, {(AMP_W-1){1'b0}}};
         FMT_SIGNMAG: code = {sign, mag};
         default:     code = twos;
      endcase
   end

   if (EXT_W > 0) begin : g_ext
      assign wide = {{EXT_W{code[AMP_W-1]}}, code};
   end else begin : g_noext
      assign wide = code;
   end

   assign nxt = bypass ? phase : wide;

   always_ff @(posedge clk) begin
      if (rst)            sample_q <= '0;
      else if (!pwr_down) sample_q <= nxt;
   end

   // R6: bypass forwards the raw phase
   assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(pwr_down) && $past(bypass)) |-> (sample_q == $past(phase)));

   // R5: upper output bits replicate the amplitude MSB in table mode
   assert_sign_ext_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(pwr_down) && !$past(bypass)) |->
         ($countones(sample_q[ADDR_W-1:AMP_W-1]) == 0 ||
          $countones(sample_q[ADDR_W-1:AMP_W-1]) == EXT_W + 1));

   // R7: output frozen while powered down
   assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pwr_down)) |-> $stable(sample_q));
endmodule

// File: rtl/dds_core.sv
module dds_core #(
   parameter int FREQ_W     = 31,
   parameter int ACC_W      = 32,
   parameter int ADDR_W     = 14,
   parameter int AMP_W      = 12,
   parameter bit ASYNC_LOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FREQ_W-1:0] freq_word,
   input  logic              load,
   input  logic [1:0]        fmt,
   input  logic              bypass,
   input  logic              pwr_down,
   output logic [ADDR_W-1:0] sample
);
   logic [FREQ_W-1:0] word_q;
   logic [ADDR_W-1:0] phase;
   logic              shp_sign;
   logic [AMP_W-2:0]  shp_mag;

   dds_tune_reg #(.FREQ_W(FREQ_W), .ASYNC_LOAD(ASYNC_LOAD)) u_tune (
      .clk(clk), .rst(rst), .pwr_down(pwr_down), .load(load),
      .word_in(freq_word), .word_q(word_q));

   dds_phase_acc #(.FREQ_W(FREQ_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
      .clk(clk), .rst(rst), .pwr_down(pwr_down), .word(word_q), .phase(phase));

   dds_parabola_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_shape (
      .en(~bypass), .addr(phase), .sign(shp_sign), .mag(shp_mag));

   dds_out_fmt #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_out (
      .clk(clk), .rst(rst), .pwr_down(pwr_down), .bypass(bypass), .fmt(fmt),
      .phase(phase), .sign(shp_sign), .mag(shp_mag), .sample_q(sample));
endmodule

// File: tb/tb_dds_core.sv
module tb_dds_core;
   logic        clk = 1'b0;
   logic        rst;
   logic [30:0] freq;
   logic        load, a_load;
   logic [1:0]  fmt;
   logic        byp, pd;
   logic [13:0] sample, a_sample;
   int          n_chk = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   dds_core #(.ASYNC_LOAD(1'b0)) dut (
      .clk(clk), .rst(rst), .freq_word(freq), .load(load), .fmt(fmt),
      .bypass(byp), .pwr_down(pd), .sample(sample));

   dds_core #(.ASYNC_LOAD(1'b1)) dut_async (
      .clk(clk), .rst(rst), .freq_word(freq), .load(a_load), .fmt(2'b00),
      .bypass(1'b1), .pwr_down(1'b0), .sample(a_sample));

   // Expected sample from the requirement formulas (R3, R5, R6)
   function automatic logic [13:0] expect_out(logic [13:0] p, logic [1:0] f, logic b);
      int x, m, tc;
      logic [11:0] v;
      if (b) return p;
      x = int'(p[12:0]);
      m = (x * (8192 - x)) / 8192;
      if (m > 2047) m = 2047;
      tc = p[13] ? -m : m;
      case (f)
         2'b01:   v = 12'(tc) ^ 12'h800;
         2'b10:   v = {p[13], 11'(m)};
         default: v = 12'(tc);
      endcase
      return {{2{v[11]}}, v};
   endfunction

   // Arithmetic reference state for the synchronous instance
   logic [31:0] m_acc;
   logic [30:0] m_fcr;
   logic [13:0] m_out;
   always @(posedge clk) begin
      if (rst) begin
         m_acc <= '0; m_fcr <= '0; m_out <= '0;
      end else if (!pd) begin
         m_out <= expect_out(m_acc[31:18], fmt, byp);
         m_acc <= m_acc + {1'b0, m_fcr};
         if (load) m_fcr <= freq;
      end
   end

   task automatic chk(string tag, logic [13:0] got, logic [13:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(string tag);
      @(posedge clk);
      @(negedge clk);
      chk(tag, sample, m_out);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [13:0] held;
      rst = 1'b1; load = 1'b0; a_load = 1'b0; freq = '0;
      fmt = 2'b00; byp = 1'b0; pd = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8", sample, 14'h0000);
      chk("R8", a_sample, 14'h0000);
      rst = 1'b0;
      step("R8"); chk("R8", sample, 14'h0000);
      step("R8");

      // R2: mixed tuning word, raw phase observed in bypass
      byp = 1'b1; freq = 31'h0123_4567; load = 1'b1; step("R4"); load = 1'b0;
      repeat (300) step("R2");

      // R1: largest tuning word
      freq = 31'h7FFF_FFFF; load = 1'b1; step("R1"); load = 1'b0;
      repeat (200) step("R1");

      // R3/R5: exhaustive phase sweep (step 1 per clock) in every format
      freq = 31'h0004_0000; load = 1'b1; step("R4"); load = 1'b0;
      byp = 1'b0;
      for (int f = 0; f < 4; f++) begin
         fmt = 2'(f);
         repeat (16390) step(f == 0 ? "R3" : "R5");
      end

      // R6: bypass on the same word
      byp = 1'b1;
      repeat (40) step("R6");

      // R4: back-to-back synchronous loads
      for (int i = 0; i < 64; i++) begin
         freq = 31'(i * 32'h0135_79BD + 7);
         load = 1'b1;
         step("R4");
      end
      load = 1'b0;
      repeat (4) step("R4");

      // R7: power-down freezes state and ignores loads
      byp = 1'b0; fmt = 2'b10; freq = 31'h0010_2030; load = 1'b1; step("R7"); load = 1'b0;
      repeat (10) step("R7");
      held = sample;
      pd = 1'b1;
      for (int i = 0; i < 25; i++) begin
         load = 1'b1; freq = 31'(i * 32'h0777_1111 + 3);
         fmt = 2'(i); byp = i[0];
         step("R7");
         chk("R7", sample, held);
      end
      load = 1'b0; fmt = 2'b10; byp = 1'b0; pd = 1'b0;
      repeat (50) step("R7");

      // R4: asynchronous strobe, captured at E2, visible at E4
      freq = 31'(32'd3 << 18); a_load = 1'b1;
      step("R4"); chk("R4", a_sample, 14'd0);   // after E0
      step("R4"); chk("R4", a_sample, 14'd0);   // E1
      step("R4"); chk("R4", a_sample, 14'd0);   // E2
      step("R4"); chk("R4", a_sample, 14'd0);   // E3
      freq = 31'(32'd5 << 18);                  // strobe still high: no reload
      step("R4"); chk("R4", a_sample, 14'd3);   // E4
      step("R4"); chk("R4", a_sample, 14'd6);   // E5
      step("R4"); chk("R4", a_sample, 14'd9);   // E6
      a_load = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule